// File: doc/BRIEF.md
# Serial Bus Bit Timing and Sampling Unit

This unit sits between the raw receive pin of a two-wire differential serial bus and the frame logic of a bus controller. From the system clock it derives a time quantum, then cuts every nominal bit into three parts: a one-quantum sync segment, a first phase segment and a second phase segment. At the end of the first phase segment it samples the line and raises a sample strobe. At the end of the second phase segment it raises a bit-boundary strobe, which the transmit side uses as the moment to put the next bit on the bus.

The receive line is looked at only on quantum ticks. A recessive-to-dominant transition between two consecutive ticks is an edge. While the frame logic reports the bus as idle, an edge restarts the bit at the sync segment (hard synchronisation). Otherwise an edge moves the sample point and the bit end by a bounded amount (resynchronisation). The sampled bit comes either from the tick at the sample point alone or from a 2-of-3 vote over the three ticks that end there.

Timing fields are loaded only while the hold input (the controller's reset mode) is high and stay frozen while it is low. The control state machine has four states: HOLD (reset mode, no strobes), SYNC (sync quantum), PH1 (first phase segment) and PH2 (second phase segment). Its transitions are: HOLD to SYNC when hold drops; SYNC to PH1 on a tick; PH1 to PH2 on the tick that ends the segment (sample); PH2 to SYNC on the tick that ends the segment (bit boundary); any running state to SYNC on an edge while the bus is idle (hard sync); any state to HOLD while hold is high.

Top module: `bit_timing_unit`

## Requirements
- R1: While reset or hold is active, both strobes are low and the sampled bit reads recessive (1).
- R2: One quantum lasts 2 × (prescaler + 1) clocks, and without edges successive bit-boundary strobes lie (seg1 + seg2 + 3) quanta apart.
- R3: The sample strobe follows a bit-boundary strobe by (seg1 + 2) quanta and precedes the next by (seg2 + 1) quanta; each strobe is one clock wide and never coincides with the other.
- R4: With the triple control low, the sampled bit equals the line value seen at the quantum tick that ends the first phase segment.
- R5: With the triple control high, the sampled bit is the 2-of-3 majority of the line at the last three quantum ticks ending at the sample point.
- R6: An edge means the line is 1 at one quantum tick and 0 at the next; an edge at the tick ending quantum k (counting from 0) of the first phase segment lengthens that segment by min(k + 1, jump + 1) quanta, so that a sample point due on that same tick is postponed.
- R7: An edge at the tick ending quantum j (from 0) of the second phase segment shortens that segment by min(seg2 − j, jump + 1) quanta.
- R8: An edge at the tick that ends the sync quantum changes no timing.
- R9: Only the first edge inside a bit adjusts timing; later edges in the same bit are ignored.
- R10: With bus idle high, an edge in any running state makes the bit-boundary strobe fire for that tick and starts a nominal bit from the sync segment.
- R11: Timing fields are captured only while hold is high; changes while hold is low have no effect on the strobes, and no strobe fires while hold stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 1 | Reset mode: loads timing fields, stops the unit |
| cfg_presc | input | 14 | Quantum prescaler value p, quantum = 2(p+1) clocks |
| cfg_seg1 | input | 4 | First phase segment length minus one |
| cfg_seg2 | input | 3 | Second phase segment length minus one |
| cfg_sjw | input | 2 | Jump width minus one |
| cfg_triple | input | 1 | 1 selects the three-tick majority vote |
| bus_idle | input | 1 | From frame logic: enables hard synchronisation |
| rx_line | input | 1 | Raw receive line, 1 recessive |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| tx_pt_stb | output | 1 | One-clock pulse at the bit boundary (transmit point) |

## Verification
Two functions can meet on one quantum tick: an edge landing on the tick that would be the sample point, and an edge landing on the tick that closes the second phase segment. The first is provoked by placing a single dominant tick exactly at the last quantum of the first phase segment; the bench then requires no sample strobe on that tick and a bit lengthened by the capped jump. The second arises in the sampling sweeps, where the vote window opens with a dominant tick at the bit end; there the bit must close on time with the boundary strobe unmoved, and hard sync is also driven onto in-bit ticks to confirm that the boundary strobe wins over a pending sample.

// File: rtl/btu_pkg.sv
package btu_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_SYNC = 2'd1,
        ST_PH1  = 2'd2,
        ST_PH2  = 2'd3
    } btu_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/btu_tq_gen.sv
module btu_tq_gen #(
    parameter int PRESC_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int CNT_W = PRESC_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // 2*(p+1) clocks per quantum: terminal count is 2p+1
    assign last = {presc, 1'b1};
    assign tick = !hold && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/btu_sampler.sv
module btu_sampler
    import btu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    input  logic samp_now,
    input  logic triple,
    input  logic line,
    output logic prev_q,
    output logic rx_bit
);
    // hist[0]: line at previous tick, hist[1]: two ticks ago
    logic [1:0] hist;
    logic       voted;

    assign voted  = vote3(hist[1], hist[0], line);
    assign prev_q = hist[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= 2'b11;
        end else if (hold) begin
            hist <= 2'b11;
        end else if (tick) begin
            hist <= {hist[0], line};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_bit <= 1'b1;
        end else if (hold) begin
            rx_bit <= 1'b1;
        end else if (samp_now) begin
            rx_bit <= triple ? voted : line;
        end
    end
endmodule

// File: rtl/btu_bit_fsm.sv
module btu_bit_fsm
    import btu_pkg::*;
#(
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tick,
    input  logic              line,
    input  logic              prev_q,
    input  logic              idle,
    input  logic [SEG1_W-1:0] seg1,
    input  logic [SEG2_W-1:0] seg2,
    input  logic [SJW_W-1:0]  sjw,
    output logic              samp_now,
    output logic              sample_stb,
    output logic              bound_stb
);
    localparam int MAX_A = (SEG1_W > SJW_W) ? SEG1_W : SJW_W;
    localparam int MAX_W = (MAX_A > SEG2_W) ? MAX_A : SEG2_W;
    localparam int LEN_W = MAX_W + 2;

    btu_state_e       st, st_n;
    logic [LEN_W-1:0] qcnt, qcnt_n;
    logic [LEN_W-1:0] plen, plen_n;
    logic             did, did_n;
    logic             bound_now;
    logic             edge_hit;
    logic [LEN_W-1:0] jump, qnext, len_t, adj;

    function automatic logic [LEN_W-1:0] lesser(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    assign jump     = LEN_W'(sjw) + 1'b1;
    assign qnext    = qcnt + 1'b1;
    assign edge_hit = tick && prev_q && !line;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_HOLD;
            qcnt <= '0;
            plen <= '0;
            did  <= 1'b0;
        end else begin
            st   <= st_n;
            qcnt <= qcnt_n;
            plen <= plen_n;
            did  <= did_n;
        end
    end

    // next state
    always_comb begin
        st_n      = st;
        qcnt_n    = qcnt;
        plen_n    = plen;
        did_n     = did;
        samp_now  = 1'b0;
        bound_now = 1'b0;
        len_t     = plen;
        adj       = '0;
        unique case (st)
            ST_HOLD: begin
                st_n   = ST_SYNC;
                qcnt_n = '0;
                did_n  = 1'b0;
            end
            ST_SYNC: begin
                if (tick) begin
                    st_n   = ST_PH1;
                    qcnt_n = '0;
                    plen_n = LEN_W'(seg1) + 1'b1;
                end
            end
            ST_PH1: begin
                if (tick) begin
                    if (edge_hit && !did) begin
                        adj   = lesser(qnext, jump);
                        len_t = plen + adj;
                        did_n = 1'b1;
                    end
                    if (qnext == len_t) begin
                        st_n     = ST_PH2;
                        qcnt_n   = '0;
                        plen_n   = LEN_W'(seg2) + 1'b1;
                        samp_now = 1'b1;
                    end else begin
                        qcnt_n = qnext;
                        plen_n = len_t;
                    end
                end
            end
            ST_PH2: begin
                if (tick) begin
                    if (edge_hit && !did) begin
                        adj   = lesser(plen - qnext, jump);
                        len_t = plen - adj;
                        did_n = 1'b1;
                    end
                    if (qnext == len_t) begin
                        st_n      = ST_SYNC;
                        qcnt_n    = '0;
                        did_n     = 1'b0;
                        bound_now = 1'b1;
                    end else begin
                        qcnt_n = qnext;
                        plen_n = len_t;
                    end
                end
            end
            default: st_n = ST_HOLD;
        endcase
        // hard synchronisation while idle
        if (idle && edge_hit && (st != ST_HOLD)) begin
            st_n      = ST_SYNC;
            qcnt_n    = '0;
            did_n     = 1'b0;
            samp_now  = 1'b0;
            bound_now = 1'b1;
        end
        if (hold) begin
            st_n      = ST_HOLD;
            qcnt_n    = '0;
            did_n     = 1'b0;
            samp_now  = 1'b0;
            bound_now = 1'b0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            bound_stb  <= 1'b0;
        end else begin
            sample_stb <= samp_now;
            bound_stb  <= bound_now;
        end
    end
endmodule

// File: rtl/bit_timing_unit.sv
module bit_timing_unit #(
    parameter int PRESC_W = 14,
    parameter int SEG1_W  = 4,
    parameter int SEG2_W  = 3,
    parameter int SJW_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_hold,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [SEG1_W-1:0]  cfg_seg1,
    input  logic [SEG2_W-1:0]  cfg_seg2,
    input  logic [SJW_W-1:0]   cfg_sjw,
    input  logic               cfg_triple,
    input  logic               bus_idle,
    input  logic               rx_line,
    output logic               rx_bit,
    output logic               sample_stb,
    output logic               tx_pt_stb
);
    logic [PRESC_W-1:0] sh_presc;
    logic [SEG1_W-1:0]  sh_seg1;
    logic [SEG2_W-1:0]  sh_seg2;
    logic [SJW_W-1:0]   sh_sjw;
    logic               sh_triple;
    logic               tick;
    logic               samp_now;
    logic               prev_q;

    // timing fields are writable only in reset mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_presc  <= '0;
            sh_seg1   <= '0;
            sh_seg2   <= '0;
            sh_sjw    <= '0;
            sh_triple <= 1'b0;
        end else if (cfg_hold) begin
            sh_presc  <= cfg_presc;
            sh_seg1   <= cfg_seg1;
            sh_seg2   <= cfg_seg2;
            sh_sjw    <= cfg_sjw;
            sh_triple <= cfg_triple;
        end
    end

    btu_tq_gen #(.PRESC_W(PRESC_W)) u_tq (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cfg_hold),
        .presc (sh_presc),
        .tick  (tick)
    );

    btu_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg_hold),
        .tick     (tick),
        .samp_now (samp_now),
        .triple   (sh_triple),
        .line     (rx_line),
        .prev_q   (prev_q),
        .rx_bit   (rx_bit)
    );

    btu_bit_fsm #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cfg_hold),
        .tick       (tick),
        .line       (rx_line),
        .prev_q     (prev_q),
        .idle       (bus_idle),
        .seg1       (sh_seg1),
        .seg2       (sh_seg2),
        .sjw        (sh_sjw),
        .samp_now   (samp_now),
        .sample_stb (sample_stb),
        .bound_stb  (tx_pt_stb)
    );
endmodule

// File: rtl/btu_checker.sv
module btu_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_hold,
    input logic rx_bit,
    input logic sample_stb,
    input logic tx_pt_stb
);
    // R3: the two strobes never fire together
    p_strobe_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_pt_stb));

    // R3: strobes are one clock wide
    p_sample_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
    p_bound_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pt_stb |=> !tx_pt_stb);

    // R11: hold keeps both strobes quiet
    p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> (!sample_stb && !tx_pt_stb));

    // R1: hold forces the sampled bit recessive
    p_hold_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> rx_bit);

    // R4: the sampled bit only moves with a sample strobe
    p_bit_moves_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hold |=> (sample_stb || $stable(rx_bit)));
endmodule

bind bit_timing_unit btu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_hold   (cfg_hold),
    .rx_bit     (rx_bit),
    .sample_stb (sample_stb),
    .tx_pt_stb  (tx_pt_stb)
);

// File: tb/sim_bit_timing_unit.sv
module sim_bit_timing_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_hold;
    logic [13:0] cfg_presc;
    logic [3:0]  cfg_seg1;
    logic [2:0]  cfg_seg2;
    logic [1:0]  cfg_sjw;
    logic        cfg_triple;
    logic        bus_idle;
    logic        rx_line;
    logic        rx_bit;
    logic        sample_stb;
    logic        tx_pt_stb;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int cp, cs1, cs2, csj;
    bit ctr;

    always #4 clk = ~clk;

    bit_timing_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_presc(cfg_presc),
        .cfg_seg1(cfg_seg1), .cfg_seg2(cfg_seg2), .cfg_sjw(cfg_sjw),
        .cfg_triple(cfg_triple), .bus_idle(bus_idle), .rx_line(rx_line),
        .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_pt_stb(tx_pt_stb)
    );

    function automatic int tq_of(int p);           return 2 * (p + 1); endfunction
    function automatic int bitlen(int s1, int s2); return s1 + s2 + 3; endfunction
    function automatic int imin(int a, int b);     return (a < b) ? a : b; endfunction
    function automatic int vote(int a, int b, int c); return (a + b + c) >= 2 ? 1 : 0; endfunction
    function automatic int pat_code(int i);
        case (i)
            0: return 0; 1: return 4; 2: return 1;
            3: return 3; 4: return 5; default: return 7;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic adv(int k);
        repeat (k) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic next_bound(output int c);
        c = 0;
        do begin @(posedge clk); c++; @(negedge clk); end
        while (!tx_pt_stb && c < 20000);
    endtask

    task automatic next_sample(output int c);
        c = 0;
        do begin @(posedge clk); c++; @(negedge clk); end
        while (!sample_stb && c < 20000);
    endtask

    // load fields in reset mode, release, align to the first bit boundary
    task automatic setup(int p, int s1, int s2, int sj, bit tr);
        int c;
        @(negedge clk);
        cfg_hold = 1'b1;
        cfg_presc = 14'(p); cfg_seg1 = 4'(s1); cfg_seg2 = 3'(s2);
        cfg_sjw = 2'(sj); cfg_triple = tr;
        cp = p; cs1 = s1; cs2 = s2; csj = sj; ctr = tr;
        rx_line = 1'b1;
        adv(3);
        cfg_hold = 1'b0;
        next_bound(c);
    endtask

    // one dominant tick n quanta after the boundary; returns clocks to next boundary
    task automatic edge_at(int n, output int tot);
        int c, tq;
        tq = tq_of(cp);
        adv(n * tq - 1);
        rx_line = 1'b0;
        adv(1);
        rx_line = 1'b1;
        if (tx_pt_stb) c = 0;
        else next_bound(c);
        tot = n * tq + c;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c, c2, tot, n, L, tq, e, k, j, code, a, b, cc, cnt;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_hold = 1'b1; cfg_presc = '0; cfg_seg1 = '0;
        cfg_seg2 = '0; cfg_sjw = '0; cfg_triple = 1'b0; bus_idle = 1'b0; rx_line = 1'b1;
        adv(5);
        // R1 reset state
        chk("R1 sample_stb in reset", int'(sample_stb), 0);
        chk("R1 tx_pt_stb in reset", int'(tx_pt_stb), 0);
        chk("R1 rx_bit in reset", int'(rx_bit), 1);
        rst_n = 1'b1;
        cnt = 0;
        rx_line = 1'b0;
        repeat (100) begin adv(1); cnt += int'(sample_stb) + int'(tx_pt_stb); end
        rx_line = 1'b1;
        chk("R11 strobes during hold", cnt, 0);
        chk("R1 rx_bit during hold", int'(rx_bit), 1);

        // R2/R3 nominal timing, directed then random
        for (int it = 0; it < 8; it++) begin
            if (it == 0) setup(0, 0, 0, 0, 0);
            else if (it == 1) setup(3, 15, 7, 3, 0);
            else setup($urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 7),
                       $urandom_range(0, 3), 0);
            tq = tq_of(cp);
            next_sample(c);
            chk("R3 boundary to sample", c, (cs1 + 2) * tq);
            next_bound(c2);
            chk("R3 sample to boundary", c2, (cs2 + 1) * tq);
            next_bound(c);
            chk("R2 bit period", c, bitlen(cs1, cs2) * tq);
        end

        // R6/R7/R8 resynchronisation at random positions
        for (int it = 0; it < 30; it++) begin
            setup($urandom_range(0, 2), $urandom_range(0, 15), $urandom_range(0, 7),
                  $urandom_range(0, 3), 0);
            tq = tq_of(cp);
            L = bitlen(cs1, cs2);
            n = $urandom_range(1, L);
            edge_at(n, tot);
            if (n == 1) begin
                chk("R8 edge in sync quantum", tot, L * tq);
            end else if (n <= cs1 + 2) begin
                k = n - 2;
                e = L + imin(k + 1, csj + 1);
                chk("R6 edge in phase 1", tot, e * tq);
            end else begin
                j = n - cs1 - 3;
                e = L - imin(cs2 - j, csj + 1);
                chk("R7 edge in phase 2", tot, e * tq);
            end
            next_bound(c);
            chk("R2 period after resync", c, L * tq);
        end

        // R6 edge on the tick that would be the sample point
        setup(1, 3, 2, 3, 0);
        tq = tq_of(cp);
        L = bitlen(cs1, cs2);
        adv(5 * tq - 1);
        rx_line = 1'b0;
        adv(1);
        rx_line = 1'b1;
        chk("R6 no sample on postponed tick", int'(sample_stb), 0);
        next_bound(c);
        chk("R6 postponed bit length", 5 * tq + c, (L + 4) * tq);

        // R9 second edge in the same bit ignored
        setup(1, 5, 3, 3, 0);
        tq = tq_of(cp);
        L = bitlen(cs1, cs2);
        adv(2 * tq - 1);
        rx_line = 1'b0; adv(1); rx_line = 1'b1;
        adv(2 * tq - 1);
        rx_line = 1'b0; adv(1); rx_line = 1'b1;
        next_bound(c);
        chk("R9 only first edge counts", 4 * tq + c, (L + 1) * tq);

        // R7 last quantum of phase 2: no shortening
        setup(0, 2, 4, 3, 0);
        tq = tq_of(cp);
        L = bitlen(cs1, cs2);
        edge_at(L, tot);
        chk("R7 edge at bit end", tot, L * tq);

        // R10 hard synchronisation
        for (int it = 0; it < 6; it++) begin
            setup($urandom_range(0, 2), $urandom_range(1, 15), $urandom_range(1, 7),
                  $urandom_range(0, 3), 0);
            tq = tq_of(cp);
            L = bitlen(cs1, cs2);
            bus_idle = 1'b1;
            n = $urandom_range(2, L - 1);
            edge_at(n, tot);
            bus_idle = 1'b0;
            chk("R10 hard sync restarts bit", tot, n * tq);
            next_bound(c);
            chk("R10 nominal bit after hard sync", c, L * tq);
        end

        // R4/R5 sampling, single and triple, seg1 = 0
        for (int it = 0; it < 8; it++) begin
            setup($urandom_range(0, 2), 0, $urandom_range(0, 7),
                  $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            tq = tq_of(cp);
            L = bitlen(cs1, cs2);
            adv(L * tq - 1);
            for (int r = 0; r < 4; r++) begin
                code = pat_code((it == 0 && r == 0) ? 2 : $urandom_range(0, 5));
                a = (code >> 2) & 1; b = (code >> 1) & 1; cc = code & 1;
                rx_line = 1'(a); adv(tq);
                rx_line = 1'(b); adv(tq);
                rx_line = 1'(cc); adv(1);
                chk("R3 sample strobe at seg1 end", int'(sample_stb), 1);
                if (ctr) chk("R5 majority sample", int'(rx_bit), vote(a, b, cc));
                else     chk("R4 single sample", int'(rx_bit), cc);
                rx_line = 1'b1;
                adv((L - 2) * tq - 1);
            end
        end

        // R11 field changes while operating are ignored
        setup(1, 4, 2, 1, 0);
        tq = tq_of(cp);
        L = bitlen(cs1, cs2);
        cfg_presc = 14'd3; cfg_seg1 = 4'd9; cfg_seg2 = 3'd6;
        next_bound(c);
        chk("R11 period ignores live edits", c, L * tq);
        next_bound(c);
        chk("R11 period still frozen", c, L * tq);
        setup(3, 9, 6, 1, 0);
        next_bound(c);
        chk("R11 new fields after reset mode", c, bitlen(9, 6) * tq_of(3));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule